// File: doc/BRIEF.md
# Scan Buffer Timing Controller

This block paces the movement of test data between a buffer stage and the wrapper scan chains of a core under test. It runs from one input clock whose rate is the number of parallel scan chains times the scan frequency. Each enabled cycle moves one bit serially. A row of modulo counters turns that bit stream into the strobes the buffer and the core need: a serial shift enable, a scan-load strobe each time a full row of chain bits has been assembled, a stack refill strobe each time a full bus word has drained from the bottom slot, and a capture strobe once a whole pattern has been scanned in.

While the buffer reports that it is empty, the controller stalls. Every strobe stays low and every counter keeps its value. Loading then resumes where it stopped, so bus delivery time and scan rate are decoupled. The same controller serves both an input (stimulus) buffer and an output (response) buffer, because their data flows are mirror images of each other.

Top module: `scan_buf_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four outputs are low after that edge and the shift count restarts from zero, so the first enabled shift after reset is shift number 1.
- R2: `shift_en` is high in the cycle after each rising edge at which `rst` is low and `buf_empty` is low, and low otherwise; each such edge counts as one shift.
- R3: `load_stb` is high after exactly those shifts whose running number (counted since reset) is a multiple of `SCAN_CHAINS`.
- R4: `refill_stb` is high after exactly those shifts whose running number is a multiple of `BUS_WIDTH`, whether or not a scan-load happens at the same shift.
- R5: `capture_stb` is high after exactly those shifts whose running number is a multiple of `SCAN_CHAINS*CHAIN_LEN`. It is then always accompanied by `load_stb`, and the scan-load count restarts for the next pattern.
- R6: An edge with `buf_empty` high produces no strobe and does not change any count; counting resumes from the held values when `buf_empty` falls.
- R7: Every strobe is a single-cycle pulse whenever its modulus is greater than one; a strobe is never high without `shift_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock at chain count times scan frequency |
| rst | input | 1 | Synchronous reset, active high |
| buf_empty | input | 1 | Buffer has no data; stalls all counting |
| shift_en | output | 1 | One serial bit moves this cycle |
| load_stb | output | 1 | Scan clock pulse: parallel row goes into the chains |
| refill_stb | output | 1 | Bottom stack slot needs a new bus word |
| capture_stb | output | 1 | Capture clock pulse: pattern fully scanned in |

## Verification
A scan-load and a stack refill fall in the same cycle whenever the shift number is a common multiple of the chain count and the bus width. A capture always shares its cycle with a scan-load, and with the defaults it lines up with a refill every sixtieth shift. The bench walks long randomly stalled runs past many such coincidences. It judges every output in every cycle against a running shift total taken modulo each period, so a design that drops or delays one of two simultaneous strobes shows up on the exact shift. Long stalls placed right before a coincidence confirm that the held counts still land the pair together.

// File: rtl/scan_buf_timer_pkg.sv
package scan_buf_timer_pkg;

    typedef struct packed {
        logic shift;
        logic load;
        logic refill;
        logic capture;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{shift: 1'b0, load: 1'b0, refill: 1'b0, capture: 1'b0};

    function automatic int unsigned cnt_width(input int unsigned modulus);
        return (modulus > 1) ? $clog2(modulus) : 1;
    endfunction

endpackage

// File: rtl/sbt_mod_counter.sv
module sbt_mod_counter
    import scan_buf_timer_pkg::*;
#(
    parameter int unsigned MODULUS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output logic wrap
);
    localparam int unsigned CW   = cnt_width(MODULUS);
    localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        wrap    = 1'b0;
        if (inc) begin
            if (state_q.cnt == LAST) begin
                state_d.cnt = '0;
                wrap        = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R6: a count never moves without an increment
    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(state_q.cnt));

    // R3: the count never leaves its modulus range
    p_count_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        state_q.cnt <= LAST);

endmodule

// File: rtl/scan_buf_timer.sv
module scan_buf_timer
    import scan_buf_timer_pkg::*;
#(
    parameter int unsigned SCAN_CHAINS = 4,
    parameter int unsigned BUS_WIDTH   = 6,
    parameter int unsigned CHAIN_LEN   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic buf_empty,
    output logic shift_en,
    output logic load_stb,
    output logic refill_stb,
    output logic capture_stb
);
    logic    active;
    logic    row_wrap;
    logic    word_wrap;
    logic    pattern_wrap;
    strobe_t strobe_d, strobe_q;

    assign active = !buf_empty;

    // bits assembled into the parallel row toward the chains
    sbt_mod_counter #(.MODULUS(SCAN_CHAINS)) i_row_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (active),
        .wrap (row_wrap)
    );

    // bits drained from the bottom stack slot
    sbt_mod_counter #(.MODULUS(BUS_WIDTH)) i_word_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (active),
        .wrap (word_wrap)
    );

    // scan-load pulses issued within the current pattern
    sbt_mod_counter #(.MODULUS(CHAIN_LEN)) i_pattern_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (row_wrap),
        .wrap (pattern_wrap)
    );

    always_comb begin
        strobe_d         = STROBE_IDLE;
        strobe_d.shift   = active;
        strobe_d.load    = row_wrap;
        strobe_d.refill  = word_wrap;
        strobe_d.capture = pattern_wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= STROBE_IDLE;
        end else begin
            strobe_q <= strobe_d;
        end
    end

    assign shift_en    = strobe_q.shift;
    assign load_stb    = strobe_q.load;
    assign refill_stb  = strobe_q.refill;
    assign capture_stb = strobe_q.capture;

    // R6: an empty buffer at an edge yields no activity after it
    p_quiet_on_empty_r6: assert property (@(posedge clk) disable iff (rst)
        $past(buf_empty) |-> !(shift_en || load_stb || refill_stb || capture_stb));

    // R7: strobes only accompany a shift
    p_strobe_needs_shift_r7: assert property (@(posedge clk) disable iff (rst)
        (load_stb || refill_stb || capture_stb) |-> shift_en);

    // R5: capture coincides with a scan-load
    p_capture_with_load_r5: assert property (@(posedge clk) disable iff (rst)
        capture_stb |-> load_stb);

    generate
        if (SCAN_CHAINS > 1) begin : g_load_pulse
            // R7: scan-load is a single-cycle pulse
            p_load_single_r7: assert property (@(posedge clk) disable iff (rst)
                load_stb |=> !load_stb);
        end
        if (BUS_WIDTH > 1) begin : g_refill_pulse
            // R7: refill is a single-cycle pulse
            p_refill_single_r7: assert property (@(posedge clk) disable iff (rst)
                refill_stb |=> !refill_stb);
        end
    endgenerate

endmodule

// File: tb/test_scan_buf_timer.sv
module test_scan_buf_timer;
    localparam int unsigned SC = 4;
    localparam int unsigned BW = 6;
    localparam int unsigned CL = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic buf_empty = 1'b1;
    logic shift_en, load_stb, refill_stb, capture_stb;

    int checks = 0;
    int fails  = 0;
    int unsigned nshift = 0;
    logic exp_sh = 0, exp_ld = 0, exp_rf = 0, exp_cp = 0;
    logic prev_ld = 0;
    bit done = 0;

    always #5 clk = ~clk;

    scan_buf_timer #(.SCAN_CHAINS(SC), .BUS_WIDTH(BW), .CHAIN_LEN(CL)) i_scan_buf_timer (
        .clk(clk), .rst(rst), .buf_empty(buf_empty),
        .shift_en(shift_en), .load_stb(load_stb),
        .refill_stb(refill_stb), .capture_stb(capture_stb)
    );

    function automatic bit multiple_of(input int unsigned n, input int unsigned m);
        return (n != 0) && (n % m == 0);
    endfunction

    task automatic check_bit(input string req, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b shift#=%0d", req, name, act, exp, nshift);
        end
    endtask

    // drive inputs for the next edge and predict its result
    task automatic step(input logic r, input logic e);
        rst = r;
        buf_empty = e;
        if (r) begin
            nshift = 0;
            {exp_sh, exp_ld, exp_rf, exp_cp} = 4'b0;
        end else if (e) begin
            {exp_sh, exp_ld, exp_rf, exp_cp} = 4'b0;
        end else begin
            nshift++;
            exp_sh = 1'b1;
            exp_ld = multiple_of(nshift, SC);
            exp_rf = multiple_of(nshift, BW);
            exp_cp = multiple_of(nshift, SC * CL);
        end
        @(negedge clk);
        if (r) begin
            check_bit("R1", "shift_en", shift_en, 1'b0);
            check_bit("R1", "load_stb", load_stb, 1'b0);
            check_bit("R1", "refill_stb", refill_stb, 1'b0);
            check_bit("R1", "capture_stb", capture_stb, 1'b0);
        end else begin
            check_bit(e ? "R6" : "R2", "shift_en", shift_en, exp_sh);
            check_bit(e ? "R6" : "R3", "load_stb", load_stb, exp_ld);
            check_bit(e ? "R6" : "R4", "refill_stb", refill_stb, exp_rf);
            check_bit(e ? "R6" : "R5", "capture_stb", capture_stb, exp_cp);
            if (SC > 1 && load_stb && prev_ld) begin
                checks++; fails++;
                $display("FAIL R7 load_stb actual=1 expected=0 (back-to-back)");
            end
        end
        prev_ld = load_stb;
    endtask

    initial begin
        void'($urandom(32'd1947));
        @(negedge clk);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);          // R1 reset state
        for (int i = 0; i < 130; i++) step(1'b0, 1'b0);        // R3 R4 R5 continuous
        for (int i = 0; i < 2000; i++)                         // R6 random stalls
            step(1'b0, ($urandom % 100) < 35);
        // stall held across a load+refill coincidence (R6)
        while (((nshift + 1) % 12) != 0) step(1'b0, 1'b0);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        // reset in mid-pattern restarts counting (R1)
        for (int i = 0; i < 7; i++) step(1'b0, 1'b0);
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 1500; i++)
            step(1'b0, ($urandom % 100) < 15);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule